// File: doc/BRIEF.md
# External Memory Bus Interface Controller

This block sits between a processor core and its external memory bus. It takes one access request per clock from the core. The request carries an address, a direction, a flag that marks program space rather than data space, and write data. The block turns each request into registered pad-side signals: a 16-bit address bus, a read/write strobe, four active-low segment enables and a predecoded I/O device select. The bidirectional data bus is presented as an output value, an output enable and an input value, so that a pad cell at chip level can close the loop.

Data space is split into four equal quarters by the two top address bits. The lowest quarter is low RAM, the next is I/O and the third is high RAM. The top quarter is on-chip and produces no external cycle. Program space always maps to the ROM segment, with one exception: whether the lower half of program space is served on chip or by external ROM is fixed by a pin sampled while reset is held. In download mode, set by two configuration bits together, the top address bit is forced low on program accesses, so a full program image can be written through a half-size window. Each segment enable can have its asserting edge held back by half a clock, which lets slow and fast devices share the bus without contention.

Top module: `extbus_ctrl`

## Requirements
- R1: While `rst_n` is low, each clock edge leaves `ext_addr_oe` and `ext_dout_oe` low, `ext_seg_n` at 4'b1111, `ext_rwn` high and `ext_dev_sel` at its inactive level. The first rising edge after release sets `ext_addr_oe` high.
- R2: A data-space request (`req_prog`=0) appears after the next rising edge. Exactly one `ext_seg_n` bit is low, chosen by `req_addr[15:14]`: 2'b00 gives bit 0 (low RAM), 2'b01 gives bit 1 (I/O) and 2'b10 gives bit 2 (high RAM). 2'b11 is on-chip and leaves all four bits high. Bit 3 is the ROM segment.
- R3: `ext_addr` shows the address of each external access after the next rising edge. It keeps the last external address through idle cycles and on-chip accesses.
- R4: `ext_rwn` is 0 during an external write cycle and 1 during read cycles and idle cycles.
- R5: During an external write cycle, `ext_dout_oe` is 1 and `ext_dout` carries the write data. `ext_dout_oe` returns to 0 in the first cycle that is not a write.
- R6: For an external read, the value on `ext_din` at the end of the bus cycle is placed on `core_rdata`, and `core_rvalid` pulses for one cycle. Both appear after the second rising edge following the request.
- R7: `boot_sel_pin` is stored at every rising edge while `rst_n` is low and held after release. A program access with address bit 15 at 0 drives ROM enable `ext_seg_n[3]` only if the stored value is 1 or `cfg_ext_rom` is 1. A program access with bit 15 at 1 always drives it.
- R8: A program-space write with `cfg_rom_write`=0 is ignored: no enable, `ext_rwn` stays 1, no data drive, and `ext_addr` is unchanged. With `cfg_rom_write`=1 it is an external ROM write.
- R9: When `cfg_rom_write` and `cfg_ext_rom` are both 1, program accesses put 0 on `ext_addr[15]`. Data accesses are not affected.
- R10: When `cfg_delay[i]` is 1, the fall of `ext_seg_n[i]` is moved to the falling clock edge that follows the rising edge that starts the access. Its rise is never delayed. Back-to-back accesses to the same segment keep it low.
- R11: A data access to address 16'h4000 drives `ext_dev_sel` active during its I/O cycle. The active level is low when `cfg_dsel_high`=0 and high when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_sel_pin | input | 1 | External program ROM select, sampled during reset |
| cfg_rom_write | input | 1 | Allow writes into program space |
| cfg_ext_rom | input | 1 | Force external ROM; with cfg_rom_write selects download alias |
| cfg_delay | input | 4 | Per-segment half-clock enable delay |
| cfg_dsel_high | input | 1 | Device select active high when 1 |
| req_valid | input | 1 | Core access request this cycle |
| req_prog | input | 1 | Request targets program space |
| req_write | input | 1 | Request is a write |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Write data |
| core_rdata | output | 16 | Captured read data |
| core_rvalid | output | 1 | Read data valid pulse |
| ext_addr | output | 16 | External address bus |
| ext_addr_oe | output | 1 | Address, strobe and enable pad drive enable |
| ext_dout | output | 16 | Data bus output value |
| ext_dout_oe | output | 1 | Data bus output enable |
| ext_din | input | 16 | Data bus input value |
| ext_rwn | output | 1 | Read (1) / write (0) strobe |
| ext_seg_n | output | 4 | Active-low segment enables: low RAM, I/O, high RAM, ROM |
| ext_dev_sel | output | 1 | Predecoded I/O device select |

## Verification
Address, strobe, data drive, device select and undelayed enables are all due one rising edge after the request. The bench applies each request on a falling edge and samples 1 ns after the next rising edge. A delayed enable is due at the falling edge after that, so it is sampled once just after the rising edge (still high) and once just after the falling edge (low). Read data is due two rising edges after the request, and the bench places `ext_din` in the bus cycle in between.

// File: rtl/extbus_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the external memory bus controller.
// Assumes four segments whose index equals the two top data-address bits.
package extbus_pkg;

    localparam int SEG_IDX_W = 2;
    localparam int NUM_SEG   = 1 << SEG_IDX_W;

    // Segment index; bit position in the enable vector.
    typedef enum logic [SEG_IDX_W-1:0] {
        SEG_LORAM = 2'd0,
        SEG_IO    = 2'd1,
        SEG_HIRAM = 2'd2,
        SEG_ROM   = 2'd3
    } seg_e;

    // Decoded view of one core request.
    typedef struct packed {
        logic ext;    // produces an external bus cycle
        logic write;  // direction
        seg_e seg;    // target segment
        logic dev;    // hits the predecoded device address
    } access_t;

endpackage

// File: rtl/extbus_boot_latch.sv
`timescale 1ns/1ps
// Stores the boot memory select pin while reset is held.
// Assumes rst_n is synchronous; the value of the last edge in reset is kept.
module extbus_boot_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic boot_ext
);

    logic boot_q;

    // Follow the pin during reset, freeze it once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q <= pin;
        end
    end

    assign boot_ext = boot_q;

endmodule

// File: rtl/extbus_decode.sv
`timescale 1ns/1ps
// Combinational request decoder: picks the segment, decides whether the
// request reaches the external bus and applies the download alias.
// Assumes the top data quarter is on-chip and program writes need permission.
module extbus_decode
    import extbus_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 16'h4000
) (
    input  logic              req_valid,
    input  logic              req_prog,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              boot_ext,
    input  logic              cfg_rom_write,
    input  logic              cfg_ext_rom,
    output access_t           acc,
    output logic [ADDR_W-1:0] out_addr
);

    localparam int TOP = ADDR_W - 1;

    logic              download;
    logic              rom_external;
    logic              prog_ok;
    logic [SEG_IDX_W-1:0] quarter;

    // Mode terms shared by the program-space branch.
    always_comb begin
        download     = cfg_rom_write & cfg_ext_rom;
        rom_external = req_addr[TOP] | boot_ext | cfg_ext_rom;
        prog_ok      = rom_external & (~req_write | cfg_rom_write);
        quarter      = req_addr[TOP -: SEG_IDX_W];
    end

    // Build the decoded access and the (possibly aliased) bus address.
    always_comb begin
        acc       = '0;
        acc.write = req_write;
        out_addr  = req_addr;
        if (req_prog) begin
            acc.seg = SEG_ROM;
            acc.ext = req_valid & prog_ok;
            if (download) begin
                out_addr[TOP] = 1'b0;
            end
        end else begin
            acc.seg = seg_e'(quarter);
            acc.ext = req_valid & (quarter != SEG_IDX_W'(SEG_ROM));
            acc.dev = req_valid & (req_addr == DEV_ADDR);
        end
    end

endmodule

// File: rtl/extbus_bus_drive.sv
`timescale 1ns/1ps
// Rising-edge bus register stage: address hold, strobe, enables,
// write data drive and read capture.
// Assumes one bus cycle per accepted request and no wait states.
module extbus_bus_drive
    import extbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  access_t           acc,
    input  logic [ADDR_W-1:0] out_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ext_din,
    output logic [ADDR_W-1:0] addr_q,
    output logic              addr_oe_q,
    output logic [NUM_SEG-1:0] en_n_q,
    output logic              rwn_q,
    output logic [DATA_W-1:0] dout_q,
    output logic              dout_oe_q,
    output logic              dev_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rvalid_q
);

    logic              ext_wr;
    logic              ext_rd;
    logic [NUM_SEG-1:0] onehot;
    logic              rd_pend_q;

    // Classify the access and form the one-hot segment select.
    always_comb begin
        ext_wr = acc.ext & acc.write;
        ext_rd = acc.ext & ~acc.write;
        onehot = '0;
        onehot[acc.seg] = acc.ext;
    end

    // Address register: holds the last external address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            addr_oe_q <= 1'b0;
        end else begin
            addr_oe_q <= 1'b1;
            if (acc.ext) begin
                addr_q <= out_addr;
            end
        end
    end

    // Control strobes: enables, direction and device select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_n_q <= '1;
            rwn_q  <= 1'b1;
            dev_q  <= 1'b0;
        end else begin
            en_n_q <= ~onehot;
            rwn_q  <= ~ext_wr;
            dev_q  <= acc.dev & acc.ext;
        end
    end

    // Write data drive: enabled only for the write cycle itself.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q    <= '0;
            dout_oe_q <= 1'b0;
        end else begin
            dout_oe_q <= ext_wr;
            if (ext_wr) begin
                dout_q <= wdata;
            end
        end
    end

    // Read capture: sample the bus at the end of the read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
            rvalid_q  <= 1'b0;
            rdata_q   <= '0;
        end else begin
            rd_pend_q <= ext_rd;
            rvalid_q  <= rd_pend_q;
            if (rd_pend_q) begin
                rdata_q <= ext_din;
            end
        end
    end

endmodule

// File: rtl/extbus_edge_delay.sv
`timescale 1ns/1ps
// Per-segment half-clock delay of the enable's asserting edge.
// A falling-edge copy is ORed with the rising-edge enable, so the
// low-going edge waits for the falling clock while the rise does not.
module extbus_edge_delay #(
    parameter int NUM_SEG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SEG-1:0] en_n_q,
    input  logic [NUM_SEG-1:0] cfg_delay,
    output logic [NUM_SEG-1:0] en_n_out
);

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        logic late_n;

        // Retime the enable on the falling clock edge.
        always_ff @(negedge clk) begin
            if (!rst_n) begin
                late_n <= 1'b1;
            end else begin
                late_n <= en_n_q[g];
            end
        end

        // Select direct or late-asserting enable for this segment.
        assign en_n_out[g] = cfg_delay[g] ? (en_n_q[g] | late_n) : en_n_q[g];
    end

endmodule

// File: rtl/extbus_ctrl.sv
`timescale 1ns/1ps
// External memory bus controller top: decode, boot select latch,
// bus register stage, enable delay and device-select polarity.
// Assumes pads are outside; each output enable drives its pad cell.
module extbus_ctrl
    import extbus_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 16,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 16'h4000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boot_sel_pin,
    input  logic               cfg_rom_write,
    input  logic               cfg_ext_rom,
    input  logic [NUM_SEG-1:0] cfg_delay,
    input  logic               cfg_dsel_high,
    input  logic               req_valid,
    input  logic               req_prog,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic [DATA_W-1:0]  core_rdata,
    output logic               core_rvalid,
    output logic [ADDR_W-1:0]  ext_addr,
    output logic               ext_addr_oe,
    output logic [DATA_W-1:0]  ext_dout,
    output logic               ext_dout_oe,
    input  logic [DATA_W-1:0]  ext_din,
    output logic               ext_rwn,
    output logic [NUM_SEG-1:0] ext_seg_n,
    output logic               ext_dev_sel
);

    logic               boot_ext;
    access_t            acc;
    logic [ADDR_W-1:0]  out_addr;
    logic [NUM_SEG-1:0] en_n_q;
    logic               dev_q;

    extbus_boot_latch u_boot (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (boot_sel_pin),
        .boot_ext (boot_ext)
    );

    extbus_decode #(
        .ADDR_W   (ADDR_W),
        .DEV_ADDR (DEV_ADDR)
    ) u_dec (
        .req_valid     (req_valid),
        .req_prog      (req_prog),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .boot_ext      (boot_ext),
        .cfg_rom_write (cfg_rom_write),
        .cfg_ext_rom   (cfg_ext_rom),
        .acc           (acc),
        .out_addr      (out_addr)
    );

    extbus_bus_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .out_addr  (out_addr),
        .wdata     (req_wdata),
        .ext_din   (ext_din),
        .addr_q    (ext_addr),
        .addr_oe_q (ext_addr_oe),
        .en_n_q    (en_n_q),
        .rwn_q     (ext_rwn),
        .dout_q    (ext_dout),
        .dout_oe_q (ext_dout_oe),
        .dev_q     (dev_q),
        .rdata_q   (core_rdata),
        .rvalid_q  (core_rvalid)
    );

    extbus_edge_delay #(
        .NUM_SEG (NUM_SEG)
    ) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_n_q    (en_n_q),
        .cfg_delay (cfg_delay),
        .en_n_out  (ext_seg_n)
    );

    // Apply the programmed device-select polarity.
    assign ext_dev_sel = cfg_dsel_high ? dev_q : ~dev_q;

endmodule

// File: rtl/extbus_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for extbus_ctrl, attached with bind below.
module extbus_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_rom_write,
    input logic        cfg_ext_rom,
    input logic        cfg_dsel_high,
    input logic        req_valid,
    input logic        req_prog,
    input logic        req_write,
    input logic [15:0] ext_addr,
    input logic        ext_addr_oe,
    input logic        ext_dout_oe,
    input logic        ext_rwn,
    input logic [3:0]  ext_seg_n,
    input logic        ext_dev_sel
);

    logic was_rst = 1'b0;

    // Remember that the previous edge saw reset asserted.
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
    end

    // R1: idle pad state after an edge in reset.
    always @(posedge clk) begin
        if (was_rst) begin
            assert_reset_idle_R1: assert (ext_seg_n == 4'hF && !ext_addr_oe
                                          && !ext_dout_oe && ext_rwn);
        end
    end

    assert_onehot_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_seg_n));

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(req_valid)) |-> $stable(ext_addr));

    assert_drive_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_dout_oe == !ext_rwn);

    assert_prog_wr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_prog && req_write && !cfg_rom_write)
        |=> (ext_seg_n[3] && ext_rwn));

    assert_alias_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_prog && cfg_rom_write && cfg_ext_rom)
        |=> !ext_addr[15]);

    assert_dsel_in_io_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_dev_sel == cfg_dsel_high) |-> !ext_seg_n[1]);

endmodule

bind extbus_ctrl extbus_ctrl_chk chk_i (.*);

// File: tb/extbus_ctrl_tb_top.sv
`timescale 1ns/1ps
module extbus_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_sel_pin = 1'b1;
    logic        cfg_rom_write = 1'b0;
    logic        cfg_ext_rom = 1'b0;
    logic [3:0]  cfg_delay = 4'h0;
    logic        cfg_dsel_high = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_prog = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [15:0] req_wdata = 16'h0;
    logic [15:0] core_rdata;
    logic        core_rvalid;
    logic [15:0] ext_addr;
    logic        ext_addr_oe;
    logic [15:0] ext_dout;
    logic        ext_dout_oe;
    logic [15:0] ext_din = 16'h0;
    logic        ext_rwn;
    logic [3:0]  ext_seg_n;
    logic        ext_dev_sel;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    extbus_ctrl dut_i (.*);

    // Vector: {prog, write, addr, exp_seg_n, exp_addr, exp_dev}
    localparam int NV = 10;
    localparam logic [38:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'h1234, 4'b1110, 16'h1234, 1'b0},
        {1'b0, 1'b1, 16'h4000, 4'b1101, 16'h4000, 1'b1},
        {1'b0, 1'b0, 16'h4001, 4'b1101, 16'h4001, 1'b0},
        {1'b0, 1'b1, 16'h8ABC, 4'b1011, 16'h8ABC, 1'b0},
        {1'b0, 1'b0, 16'hC010, 4'b1111, 16'h8ABC, 1'b0},
        {1'b1, 1'b0, 16'h0100, 4'b0111, 16'h0100, 1'b0},
        {1'b1, 1'b0, 16'h9000, 4'b0111, 16'h9000, 1'b0},
        {1'b1, 1'b1, 16'h0200, 4'b1111, 16'h9000, 1'b0},
        {1'b0, 1'b0, 16'h3FFF, 4'b1110, 16'h3FFF, 1'b0},
        {1'b0, 1'b1, 16'h7FFF, 4'b1101, 16'h7FFF, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive a request on the falling edge, then sample after the rising edge.
    task automatic access(input bit prog, input bit wr, input logic [15:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_prog  = prog;
        req_write = wr;
        req_addr  = a;
        req_wdata = a ^ 16'h5A5A;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input bit pin);
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        boot_sel_pin = pin;
        repeat (3) @(posedge clk);
        #1;
        chk(ext_seg_n == 4'hF && !ext_addr_oe && !ext_dout_oe && ext_rwn
            && ext_dev_sel == 1'b1, "R1 reset state",
            {ext_seg_n, ext_addr_oe, ext_dout_oe, ext_rwn, ext_dev_sel},
            {4'hF, 1'b0, 1'b0, 1'b1, 1'b1});
        @(negedge clk);
        rst_n = 1'b1;
        boot_sel_pin = ~pin;
        @(posedge clk);
        #1;
        chk(ext_addr_oe == 1'b1, "R1 drive after release", ext_addr_oe, 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        do_reset(1'b1);

        // Vector table: boot select high, no delay, default polarity.
        for (int i = 0; i < NV; i++) begin
            logic        v_prog, v_wr, v_dev, e_rwn;
            logic [15:0] v_addr, e_addr;
            logic [3:0]  e_seg;
            string       tag;
            {v_prog, v_wr, v_addr, e_seg, e_addr, v_dev} = VEC[i];
            e_rwn = !(v_wr && e_seg != 4'hF);
            tag = v_prog ? ((v_wr && e_seg == 4'hF) ? "R8" : "R7") : "R2";
            access(v_prog, v_wr, v_addr);
            chk(ext_seg_n == e_seg, tag, ext_seg_n, e_seg);
            chk(ext_addr == e_addr, "R3 address", ext_addr, e_addr);
            chk(ext_rwn == e_rwn, "R4 strobe", ext_rwn, e_rwn);
            chk(ext_dout_oe == !e_rwn, "R5 data enable", ext_dout_oe, !e_rwn);
            if (!e_rwn) begin
                chk(ext_dout == (v_addr ^ 16'h5A5A), "R5 write data", ext_dout,
                    v_addr ^ 16'h5A5A);
            end
            chk(ext_dev_sel == !v_dev, "R11 device select", ext_dev_sel, !v_dev);
        end

        // Idle after a write: data released, address held.
        idle();
        chk(ext_dout_oe == 1'b0, "R5 release", ext_dout_oe, 0);
        chk(ext_rwn == 1'b1, "R4 idle", ext_rwn, 1);
        chk(ext_addr == 16'h7FFF, "R3 hold", ext_addr, 16'h7FFF);
        chk(ext_seg_n == 4'hF, "R2 idle", ext_seg_n, 4'hF);

        // R6: read data capture two edges after the request.
        access(1'b0, 1'b0, 16'h0040);
        ext_din = 16'hBEEF;
        chk(core_rvalid == 1'b0, "R6 not yet valid", core_rvalid, 0);
        idle();
        chk(core_rvalid == 1'b1 && core_rdata == 16'hBEEF, "R6 read data",
            {core_rvalid, core_rdata}, {1'b1, 16'hBEEF});
        idle();
        chk(core_rvalid == 1'b0, "R6 single pulse", core_rvalid, 0);

        // R10: half-clock delay on the I/O enable only.
        cfg_delay = 4'b0010;
        access(1'b0, 1'b0, 16'h4002);
        chk(ext_seg_n[1] == 1'b1, "R10 delayed not yet low", ext_seg_n[1], 1);
        @(negedge clk);
        #1;
        chk(ext_seg_n[1] == 1'b0, "R10 low at falling edge", ext_seg_n[1], 0);
        req_addr = 16'h4003;
        @(posedge clk);
        #1;
        chk(ext_seg_n[1] == 1'b0, "R10 back-to-back stays low", ext_seg_n[1], 0);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        chk(ext_seg_n[1] == 1'b1, "R10 rise not delayed", ext_seg_n[1], 1);
        access(1'b0, 1'b0, 16'h0010);
        chk(ext_seg_n == 4'b1110, "R10 undelayed segment", ext_seg_n, 4'b1110);
        cfg_delay = 4'h0;

        // R11: active-high device select.
        cfg_dsel_high = 1'b1;
        access(1'b0, 1'b0, 16'h4000);
        chk(ext_dev_sel == 1'b1, "R11 active high", ext_dev_sel, 1);
        idle();
        chk(ext_dev_sel == 1'b0, "R11 inactive high mode", ext_dev_sel, 0);
        cfg_dsel_high = 1'b0;

        // R8 and R9: ROM write permitted, then download alias.
        cfg_rom_write = 1'b1;
        access(1'b1, 1'b1, 16'h8005);
        chk(ext_seg_n == 4'b0111 && ext_addr == 16'h8005 && !ext_rwn,
            "R8 permitted ROM write", {ext_seg_n, ext_addr, ext_rwn},
            {4'b0111, 16'h8005, 1'b0});
        cfg_ext_rom = 1'b1;
        access(1'b1, 1'b1, 16'hC123);
        chk(ext_addr == 16'h4123 && ext_seg_n == 4'b0111, "R9 alias",
            {ext_seg_n, ext_addr}, {4'b0111, 16'h4123});
        access(1'b0, 1'b0, 16'h8001);
        chk(ext_addr == 16'h8001, "R9 data unaffected", ext_addr, 16'h8001);
        idle();
        cfg_rom_write = 1'b0;
        cfg_ext_rom = 1'b0;

        // R7: reset with the pin low; the pin changes after release.
        do_reset(1'b0);
        access(1'b0, 1'b0, 16'h2222);
        access(1'b1, 1'b0, 16'h0100);
        chk(ext_seg_n == 4'hF, "R7 internal ROM", ext_seg_n, 4'hF);
        chk(ext_addr == 16'h2222, "R7 address held", ext_addr, 16'h2222);
        access(1'b1, 1'b0, 16'h8100);
        chk(ext_seg_n == 4'b0111, "R7 upper program external", ext_seg_n, 4'b0111);
        cfg_ext_rom = 1'b1;
        access(1'b1, 1'b0, 16'h0100);
        chk(ext_seg_n == 4'b0111 && ext_addr == 16'h0100, "R7 forced external",
            {ext_seg_n, ext_addr}, {4'b0111, 16'h0100});
        idle();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule